// File: doc/BRIEF.md
# Phase-Accumulator PWM with Staged Update

This block drives one pulse-width-modulated output from a single 32-bit control word. The output rate is not set by a period counter. A programmable base-unit step is added to a phase accumulator of `BU_W` bits on every clock while the channel is on. The top eight bits of that accumulator act as the count within an output cycle. The output is high once that count has reached an on-time divisor. A larger divisor therefore gives a shorter high phase. The output frequency is `base_unit * f_clk / 2^BU_W`.

Software never writes the running settings directly. A write places the base unit and the divisor into a staging copy. Setting the update-request bit asks for them to be used. The block moves the staged pair into the active copy when the accumulator wraps, which is the start of the next output cycle, and then clears the request bit itself. While a request is outstanding, further field writes are dropped, so a half-applied configuration cannot arise. When the channel is off, or has no valid rate yet, there is no cycle to wait for and the request is taken on the next clock.

Top module: `phase_pwm`

## Requirements
- R1: After reset `rd_data` reads 0 and `pwm_out` is low: enable off, no request pending, and all staged and active fields zero.
- R2: Control word layout: bit 31 is the enable, bit 30 is the update request, bits `[8+BU_W-1:8]` are the base unit and bits `[7:0]` are the on-time divisor. A read returns the staged fields, the enable bit and the live request bit. Bits 29 down to `8+BU_W` always read 0.
- R3: While enabled, the accumulator advances by the active base unit on every clock, so one output cycle lasts `2^BU_W / base_unit` clocks (512 clocks for base unit 0x80 at `BU_W`=16).
- R4: The output is high while the cycle count (accumulator bits `[BU_W-1:BU_W-8]`) is greater than or equal to the active divisor. Over one cycle the high time is `(256 - divisor)` count steps. Divisor 0 gives a constant high and divisor 255 gives one step of high.
- R5: When the enable is 0, the output is low and the accumulator is held at zero. Counting starts from zero on the first clock after the enable is registered.
- R6: With the channel enabled and a non-zero active base unit, a pending request is applied on the clock edge where the accumulator wraps. On that edge the staged fields become active and bit 30 clears. Until then the old settings drive the output and bit 30 reads 1.
- R7: When the enable is 0, or the active base unit is 0, a pending request is applied on the clock edge that follows the one that set it.
- R8: A write made while a request is pending leaves the staged fields and the request bit unchanged. Every write still updates the enable bit.
- R9: A write with bit 30 clear changes only the staged copy. The output keeps running on the active settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Readback of the control word |
| pwm_out | output | 1 | PWM output |

## Verification
The checker watches four things on every clock. The output stays low and the count stays at zero while the channel is off. The staged fields freeze under a write made while a request is pending. The request bit only drops at a wrap, or in the idle case. The active pair only changes when a request was outstanding. Some behaviour can only be shown by the bench scenarios, because it needs a whole cycle to be measured: that the rise-to-rise period and the high time match the base unit and the divisor, that the request clears on exactly the 1024th edge after a synchronised start, and that a write without a request leaves the measured waveform untouched.

// File: rtl/phpwm_pkg.sv
`timescale 1ns/1ps
package phpwm_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned EN_POS   = 31;
   localparam int unsigned REQ_POS  = 30;
   localparam int unsigned DIV_W    = 8;
   localparam int unsigned STEP_LSB = DIV_W;
   localparam int unsigned STEP_MAX = REQ_POS - STEP_LSB;

   typedef logic [DIV_W-1:0] ontime_t;
endpackage

// File: rtl/phpwm_regs.sv
`timescale 1ns/1ps
module phpwm_regs
   import phpwm_pkg::*;
#(
   parameter int unsigned BU_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic              en_q,
   output logic              req_q,
   output logic [BU_W-1:0]   stg_bu,
   output ontime_t           stg_div
);
   logic accept;

   assign accept = wr_en && !req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr_en) begin
         en_q <= wr_data[EN_POS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         stg_bu  <= '0;
         stg_div <= '0;
      end else if (accept) begin
         req_q   <= wr_data[REQ_POS];
         stg_bu  <= wr_data[STEP_LSB +: BU_W];
         stg_div <= wr_data[DIV_W-1:0];
      end else if (take) begin
         req_q   <= 1'b0;
      end
   end
endmodule

// File: rtl/phpwm_accum.sv
`timescale 1ns/1ps
module phpwm_accum
   import phpwm_pkg::*;
#(
   parameter int unsigned BU_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [BU_W-1:0] step,
   output ontime_t         cnt,
   output logic            wrap
);
   localparam int unsigned SUM_W = BU_W + 1;

   logic [BU_W-1:0]  phase_q;
   logic [SUM_W-1:0] sum;

   assign sum  = {1'b0, phase_q} + {1'b0, step};
   assign wrap = run && sum[BU_W];
   assign cnt  = phase_q[BU_W-1 -: DIV_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (run) begin
         phase_q <= sum[BU_W-1:0];
      end else begin
         phase_q <= '0;
      end
   end
endmodule

// File: rtl/phpwm_active.sv
`timescale 1ns/1ps
module phpwm_active
   import phpwm_pkg::*;
#(
   parameter int unsigned BU_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pending,
   input  logic            run,
   input  logic            wrap,
   input  logic [BU_W-1:0] stg_bu,
   input  ontime_t         stg_div,
   output logic            take,
   output logic [BU_W-1:0] act_bu,
   output ontime_t         act_div
);
   logic idle;

   assign idle = !run || (act_bu == '0);
   assign take = pending && (wrap || idle);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_bu  <= '0;
         act_div <= '0;
      end else if (take) begin
         act_bu  <= stg_bu;
         act_div <= stg_div;
      end
   end
endmodule

// File: rtl/phpwm_compare.sv
`timescale 1ns/1ps
module phpwm_compare
   import phpwm_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    run,
   input  ontime_t cnt,
   input  ontime_t thresh,
   output logic    out
);
   logic hit;

   assign hit = run && (cnt >= thresh);

   generate
      if (REG_OUT) begin : g_flop
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_q <= 1'b0;
            end else begin
               out_q <= hit;
            end
         end
         assign out = out_q;
      end else begin : g_comb
         assign out = hit;
      end
   endgenerate
endmodule

// File: rtl/phase_pwm.sv
`timescale 1ns/1ps
module phase_pwm
   import phpwm_pkg::*;
#(
   parameter int unsigned BU_W    = 16,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              pwm_out
);
   generate
      if (BU_W < DIV_W || BU_W > STEP_MAX) begin : g_bad_width
         $error("phase_pwm: BU_W must lie between DIV_W and STEP_MAX");
      end
   endgenerate

   logic            en_q;
   logic            req_q;
   logic            take;
   logic            wrap;
   logic [BU_W-1:0] stg_bu;
   logic [BU_W-1:0] act_bu;
   ontime_t         stg_div;
   ontime_t         act_div;
   ontime_t         cnt;

   phpwm_regs #(.BU_W(BU_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .en_q    (en_q),
      .req_q   (req_q),
      .stg_bu  (stg_bu),
      .stg_div (stg_div)
   );

   phpwm_active #(.BU_W(BU_W)) u_active (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (req_q),
      .run     (en_q),
      .wrap    (wrap),
      .stg_bu  (stg_bu),
      .stg_div (stg_div),
      .take    (take),
      .act_bu  (act_bu),
      .act_div (act_div)
   );

   phpwm_accum #(.BU_W(BU_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q),
      .step  (act_bu),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   phpwm_compare #(.REG_OUT(REG_OUT)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (en_q),
      .cnt    (cnt),
      .thresh (act_div),
      .out    (pwm_out)
   );

   always_comb begin
      rd_data                   = '0;
      rd_data[EN_POS]           = en_q;
      rd_data[REQ_POS]          = req_q;
      rd_data[STEP_LSB +: BU_W] = stg_bu;
      rd_data[DIV_W-1:0]        = stg_div;
   end
endmodule

// File: rtl/phpwm_chk.sv
`timescale 1ns/1ps
module phpwm_chk
   import phpwm_pkg::*;
#(
   parameter int unsigned BU_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            en_q,
   input logic            req_q,
   input logic            wrap,
   input logic [BU_W-1:0] stg_bu,
   input logic [BU_W-1:0] act_bu,
   input ontime_t         stg_div,
   input ontime_t         act_div,
   input ontime_t         cnt,
   input logic            pwm_out
);
   a_r5_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !$past(en_q)) |-> !pwm_out)
      else $error("a_r5_low_when_off");

   a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (cnt == '0))
      else $error("a_r5_count_held");

   a_r8_staged_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && wr_en) |=> ($stable(stg_bu) && $stable(stg_div) && req_q))
      else $error("a_r8_staged_frozen");

   a_r6_clear_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(wrap || !en_q || (act_bu == '0)))
      else $error("a_r6_clear_at_wrap");

   a_r9_active_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_bu != $past(act_bu)) || (act_div != $past(act_div))) |-> $past(req_q))
      else $error("a_r9_active_needs_req");
endmodule

bind phase_pwm phpwm_chk #(.BU_W(BU_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .en_q    (en_q),
   .req_q   (req_q),
   .wrap    (wrap),
   .stg_bu  (stg_bu),
   .act_bu  (act_bu),
   .stg_div (stg_div),
   .act_div (act_div),
   .cnt     (cnt),
   .pwm_out (pwm_out)
);

// File: tb/phase_pwm_tb.sv
`timescale 1ns/1ps
module phase_pwm_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   phase_pwm u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .pwm_out (pwm_out)
   );

   // step, divisor, expected high clocks, expected period (0: constant-high case)
   localparam int NV = 7;
   localparam logic [55:0] VEC [NV] = '{
      {16'h0080, 8'd128, 16'd256,  16'd512},
      {16'h0080, 8'd192, 16'd128,  16'd512},
      {16'h0040, 8'd64,  16'd768,  16'd1024},
      {16'h0080, 8'd255, 16'd2,    16'd512},
      {16'h0020, 8'd200, 16'd448,  16'd2048},
      {16'h0100, 8'd1,   16'd255,  16'd256},
      {16'h0080, 8'd0,   16'd512,  16'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic en, input logic req, input logic [15:0] bu, input logic [7:0] dv);
      wr_data = {en, req, 6'b0, bu, dv};
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic load(input logic [15:0] bu, input logic [7:0] dv);
      wr(1'b0, 1'b1, bu, dv);
      chk("R7 request set while off", 32'(rd_data[30]), 32'd1);
      @(negedge clk);
      chk("R7 request taken while off", 32'(rd_data[30]), 32'd0);
      wr(1'b1, 1'b0, bu, dv);
   endtask

   task automatic measure(input string tag, input int exp_hi, input int exp_per);
      int  hi;
      int  per;
      int  guard;
      bit  prev;
      bit  seen;
      prev = pwm_out;
      seen = 1'b0;
      for (int i = 0; i < 5000 && !seen; i++) begin
         @(negedge clk);
         if (!prev && pwm_out) seen = 1'b1;
         prev = pwm_out;
      end
      hi = 1;
      per = 1;
      seen = 1'b0;
      guard = 0;
      while (!seen && guard < 5000) begin
         @(negedge clk);
         guard++;
         if (!prev && pwm_out) begin
            seen = 1'b1;
         end else begin
            per++;
            if (pwm_out) hi++;
         end
         prev = pwm_out;
      end
      chk({tag, " period"}, 32'(per), 32'(exp_per));
      chk({tag, " high time"}, 32'(hi), 32'(exp_hi));
   endtask

   task automatic wait_clear();
      for (int i = 0; i < 5000 && rd_data[30]; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rd_data after reset", rd_data, 32'h0);
      chk("R1 pwm_out after reset", 32'(pwm_out), 32'd0);

      // R2 layout, unused bits 29:24 read zero
      wr_data = 32'h3F12_3456;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R2 field readback", rd_data, 32'h0012_3456);

      // R7 zero active step: request taken next edge even while enabled
      wr(1'b1, 1'b1, 16'h0080, 8'h10);
      chk("R7 request visible, R2 layout", rd_data, 32'hC000_8010);
      @(negedge clk);
      chk("R7 request taken with zero step", rd_data, 32'h8000_8010);

      // R3 and R4 rate and duty table
      for (int v = 0; v < NV; v++) begin
         load(VEC[v][55:40], VEC[v][39:32]);
         if (VEC[v][15:0] == 16'd0) begin
            int hi = 0;
            for (int k = 0; k < 512; k++) begin
               @(negedge clk);
               if (pwm_out) hi++;
            end
            chk("R4 divisor zero constant high", 32'(hi), 32'(VEC[v][31:16]));
         end else begin
            measure($sformatf("R3/R4 vector %0d", v), int'(VEC[v][31:16]), int'(VEC[v][15:0]));
         end
      end

      // R5 disable forces low (last vector left output high)
      chk("R5 output high before disable", 32'(pwm_out), 32'd1);
      wr(1'b0, 1'b0, 16'h0080, 8'd0);
      chk("R5 output low when disabled", 32'(pwm_out), 32'd0);

      // R8 writes during a pending request
      load(16'h0040, 8'd64);
      measure("R3 settle 0x40", 768, 1024);
      wr(1'b1, 1'b1, 16'h0080, 8'd10);
      chk("R8 pending request staged", rd_data, 32'hC000_800A);
      wr(1'b1, 1'b0, 16'h0020, 8'd20);
      chk("R8 write ignored while pending", rd_data, 32'hC000_800A);
      wait_clear();
      chk("R6 request cleared", 32'(rd_data[30]), 32'd0);
      measure("R8 first staged settings applied", 492, 512);

      // R6 boundary timing from a synchronised start
      load(16'h0040, 8'd50);
      wr(1'b0, 1'b0, 16'h0040, 8'd50);
      repeat (2) @(negedge clk);
      wr(1'b1, 1'b0, 16'h0040, 8'd50);
      wr(1'b1, 1'b1, 16'h0080, 8'd100);
      repeat (1021) @(negedge clk);
      chk("R6 pending before wrap (edge 1022)", 32'(rd_data[30]), 32'd1);
      @(negedge clk);
      chk("R6 pending before wrap (edge 1023)", 32'(rd_data[30]), 32'd1);
      chk("R6 old divisor still drives output", 32'(pwm_out), 32'd1);
      @(negedge clk);
      chk("R6 cleared on wrap edge", 32'(rd_data[30]), 32'd0);
      chk("R6 new divisor after wrap", 32'(pwm_out), 32'd0);
      measure("R6 new settings", 312, 512);

      // R9 staging write without request leaves output alone
      wr(1'b1, 1'b0, 16'h0020, 8'd7);
      chk("R9 staged readback", rd_data, 32'h8000_2007);
      measure("R9 output unchanged", 312, 512);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule